// File: doc/BRIEF.md
# Three-Backplane Multiplexed LCD Segment Driver

This block drives a triplexed liquid crystal panel showing four full digits, a leading half digit ("1"), a minus sign, four decimal points and two annunciators (low battery and continuity). It takes already-latched digit codes and flag bits. It produces level codes for three backplanes, twelve segment lines and one annunciator square wave. Each level code selects one of three levels: low rail, mid bias, or high rail. A separate level generator turns these codes into voltages.

Each segment line carries three segments, one per backplane. A frame is six equal slots. In the first three slots each backplane in turn is driven to the high rail. In the last three slots each is driven to the low rail. Every wire therefore averages to zero over a frame. A segment is lit by driving its line to the rail opposite its active backplane. The annunciator output always sits on that opposite rail, so any extra annunciator tied to it is lit on every backplane. Full digits with no value to show are blanked: the codes above nine, and leading zeros. The decimal points stay under direct control.

Top module: `lcd_triplex_drv`

## Requirements
- R1: While rstN is low, every backplane, segment-line and annunciator output holds the bias code 2'b01.
- R2: Level codes are 2'b00 low rail, 2'b01 bias and 2'b10 high rail. A frame has six slots of SLOT_CYCLES clocks each. Slot 0 starts at the first clock edge after reset release. Slots 0, 1 and 2 drive backplane 1, 2 and 3 (bpLvl bits [1:0], [3:2], [5:4]) to high rail, one at a time. Slots 3, 4 and 5 drive them to low rail in the same order. A backplane that is not active holds bias.
- R3: annLvl is low rail in slots 0 to 2 and high rail in slots 3 to 5.
- R4: A lit segment drives its line to the rail opposite its active backplane: low in slots 0 to 2, high in slots 3 to 5. An unlit segment drives its line to bias.
- R5: Line i occupies segLvl[2i+1:2i]. For digit d (1 = least significant, code at digits[4d-1:4d-4]), line 3(d-1) carries B, C and an extra segment. Line 3(d-1)+1 carries A, G and D. Line 3(d-1)+2 carries F, E and the decimal point of digit d. Within each line, the segments are listed in backplane order 1, 2, 3.
- R6: The extra segments on backplane 3 are: continuity (contOn) on line 0, low battery (lowBat) on line 3, minus sign (signOn) on line 6, and the half digit (halfOn) on line 9.
- R7: Codes 0 to 9 light these segments: 0 ABCDEF, 1 BC, 2 ABDEG, 3 ABCDG, 4 BCFG, 5 ACDFG, 6 ACDEFG, 7 ABC, 8 ABCDEFG, 9 ABCDFG.
- R8: Codes 10 to 15 light no segment of their digit.
- R9: With halfOn low, a zero in digit 4, 3 or 2 is blanked when every higher full digit is 0 or a code above 9. With halfOn high, or in digit 1, zero is shown.
- R10: dpEn[d-1] lights the decimal point of digit d whether or not that digit is blanked.
- R11: A change on any data input appears on the outputs from the first clock edge after it, in whatever slot is then current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| digits | input | 16 | Four 4-bit digit codes, digit 1 in bits [3:0] |
| dpEn | input | 4 | Decimal point enables, bit d-1 for digit d |
| signOn | input | 1 | Minus sign on |
| halfOn | input | 1 | Leading half digit on |
| lowBat | input | 1 | Low battery annunciator on |
| contOn | input | 1 | Continuity annunciator on |
| bpLvl | output | 6 | Backplane level codes, 2 bits each |
| segLvl | output | 24 | Segment line level codes, 2 bits each |
| annLvl | output | 2 | Annunciator square wave level code |

## Verification
The decimal point of a digit and that digit's leading-zero blanking meet on the same line in the same backplane 3 slot. The bench provokes this by sweeping every decimal point and flag combination with all digits at zero and the half digit both on and off. It judges each line slot against an arithmetic model built from the requirements. A second collision comes from changing inputs at arbitrary slot positions, including the wrap from the last low-rail slot back to the first high-rail slot. Every cycle after each change is compared against the model for the slot the bench counts from reset.

// File: rtl/lcd_triplex_pkg.sv
package lcd_triplex_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int NUM_BP     = 3;
  localparam int LINES      = NUM_BP * NUM_DIGITS;
  localparam int LVL_W      = 2;
  localparam int SLOTS      = 2 * NUM_BP;

  localparam logic [LVL_W-1:0] LVL_LOW  = 2'b00;
  localparam logic [LVL_W-1:0] LVL_BIAS = 2'b01;
  localparam logic [LVL_W-1:0] LVL_HIGH = 2'b10;

  typedef struct packed {
    logic [1:0] activeBp;
    logic       negHalf;
  } slot_strobe_t;

  // segment vector bit order: [0]=A ... [6]=G
  function automatic logic [6:0] sevenSeg(input logic [3:0] code);
    logic [6:0] s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcd_triplex_ctrl.sv
module lcd_triplex_ctrl
  import lcd_triplex_pkg::*;
#(
  parameter int SLOT_CYCLES = 100
) (
  input  logic         clk,
  input  logic         rstN,
  output slot_strobe_t strobe
);
  localparam int CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [2:0] SLOT_LAST = 3'(SLOTS - 1);
  localparam logic [2:0] HALF_SLOTS = 3'(NUM_BP);

  logic [CNT_W-1:0] cycleCnt;
  logic [2:0]       slotIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
      slotIdx  <= '0;
    end else if (cycleCnt == CNT_LAST) begin
      cycleCnt <= '0;
      slotIdx  <= (slotIdx == SLOT_LAST) ? 3'd0 : slotIdx + 3'd1;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  logic [2:0] bpWide;
  always_comb begin
    strobe.negHalf = (slotIdx >= HALF_SLOTS);
    bpWide         = strobe.negHalf ? (slotIdx - HALF_SLOTS) : slotIdx;
    strobe.activeBp = bpWide[1:0];
  end
endmodule

// File: rtl/lcd_triplex_digit.sv
module lcd_triplex_digit
  import lcd_triplex_pkg::*;
(
  input  logic [3:0] code,
  input  logic       blank,
  output logic [6:0] segs
);
  always_comb begin
    if (blank) segs = 7'h00;
    else       segs = sevenSeg(code);
  end
endmodule

// File: rtl/lcd_triplex_datapath.sv
module lcd_triplex_datapath
  import lcd_triplex_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  slot_strobe_t                strobe,
  input  logic [4*NUM_DIGITS-1:0]     digits,
  input  logic [NUM_DIGITS-1:0]       dpEn,
  input  logic                        signOn,
  input  logic                        halfOn,
  input  logic                        lowBat,
  input  logic                        contOn,
  output logic [LVL_W*NUM_BP-1:0]     bpLvl,
  output logic [LVL_W*LINES-1:0]      segLvl,
  output logic [LVL_W-1:0]            annLvl
);
  logic [6:0]            digSegs [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] blankDig;
  logic [NUM_DIGITS:1]   leadRun;
  logic [NUM_DIGITS-1:0] extraBit;
  logic [2:0]            lineSegs [LINES];

  assign leadRun[NUM_DIGITS] = ~halfOn;
  assign extraBit = {halfOn, signOn, lowBat, contOn};

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    logic [3:0] code;
    assign code = digits[4*k +: 4];
    if (k == 0) begin : g_ls
      assign blankDig[k] = 1'b0;
    end else begin : g_hi
      assign leadRun[k]  = leadRun[k+1] & ((code == 4'd0) | (code > 4'd9));
      assign blankDig[k] = leadRun[k+1] & (code == 4'd0);
    end
    lcd_triplex_digit dec_i (
      .code (code),
      .blank(blankDig[k]),
      .segs (digSegs[k])
    );
    // bit 0 = backplane 1, bit 1 = backplane 2, bit 2 = backplane 3
    assign lineSegs[3*k]   = {extraBit[k], digSegs[k][2], digSegs[k][1]};
    assign lineSegs[3*k+1] = {digSegs[k][3], digSegs[k][6], digSegs[k][0]};
    assign lineSegs[3*k+2] = {dpEn[k], digSegs[k][4], digSegs[k][5]};
  end

  function automatic logic pickBp(input logic [2:0] trio, input logic [1:0] bp);
    logic v;
    case (bp)
      2'd0:    v = trio[0];
      2'd1:    v = trio[1];
      2'd2:    v = trio[2];
      default: v = 1'b0;
    endcase
    return v;
  endfunction

  logic [LVL_W-1:0] onRail, activeRail;
  logic [LVL_W*NUM_BP-1:0] bpNext;
  logic [LVL_W*LINES-1:0]  segNext;

  always_comb begin
    onRail     = strobe.negHalf ? LVL_HIGH : LVL_LOW;
    activeRail = strobe.negHalf ? LVL_LOW  : LVL_HIGH;
    for (int b = 0; b < NUM_BP; b++) begin
      bpNext[LVL_W*b +: LVL_W] = (strobe.activeBp == 2'(b)) ? activeRail : LVL_BIAS;
    end
    for (int i = 0; i < LINES; i++) begin
      segNext[LVL_W*i +: LVL_W] = pickBp(lineSegs[i], strobe.activeBp) ? onRail : LVL_BIAS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpLvl  <= {NUM_BP{LVL_BIAS}};
      segLvl <= {LINES{LVL_BIAS}};
      annLvl <= LVL_BIAS;
    end else begin
      bpLvl  <= bpNext;
      segLvl <= segNext;
      annLvl <= onRail;
    end
  end
endmodule

// File: rtl/lcd_triplex_drv.sv
module lcd_triplex_drv
  import lcd_triplex_pkg::*;
#(
  parameter int SLOT_CYCLES = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] digits,
  input  logic [3:0]  dpEn,
  input  logic        signOn,
  input  logic        halfOn,
  input  logic        lowBat,
  input  logic        contOn,
  output logic [5:0]  bpLvl,
  output logic [23:0] segLvl,
  output logic [1:0]  annLvl
);
  slot_strobe_t strobe;

  lcd_triplex_ctrl #(.SLOT_CYCLES(SLOT_CYCLES)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  lcd_triplex_datapath dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .digits(digits),
    .dpEn  (dpEn),
    .signOn(signOn),
    .halfOn(halfOn),
    .lowBat(lowBat),
    .contOn(contOn),
    .bpLvl (bpLvl),
    .segLvl(segLvl),
    .annLvl(annLvl)
  );
endmodule

// File: rtl/lcd_triplex_chk.sv
module lcd_triplex_chk
  import lcd_triplex_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  bpLvl,
  input logic [23:0] segLvl,
  input logic [1:0]  annLvl
);
  logic       started;
  logic [2:0] activeMask;
  logic [1:0] activeRail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  always_comb begin
    activeRail = 2'b00;
    for (int b = 0; b < 3; b++) begin
      activeMask[b] = (bpLvl[2*b +: 2] != LVL_BIAS);
      if (activeMask[b]) activeRail = activeRail | bpLvl[2*b +: 2];
    end
  end

  // R1: outputs sit at bias while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_bias: assert (bpLvl == 6'b010101 && annLvl == LVL_BIAS &&
                               segLvl == {12{LVL_BIAS}});
    end
  end

  // R2: exactly one backplane is off bias once running
  a_r2_one_active: assert property (@(posedge clk) disable iff (!rstN)
    started |-> ($countones(activeMask) == 1 &&
                 (activeRail == LVL_HIGH || activeRail == LVL_LOW)));

  // R2: backplanes take turns in order 1, 2, 3
  a_r2_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started) && activeMask != $past(activeMask)) |->
      (activeMask == {$past(activeMask[1:0]), $past(activeMask[2])}));

  // R3: annunciator sits on the rail opposite the active backplane
  a_r3_ann_opposes: assert property (@(posedge clk) disable iff (!rstN)
    started |-> ((activeRail == LVL_HIGH && annLvl == LVL_LOW) ||
                 (activeRail == LVL_LOW  && annLvl == LVL_HIGH)));

  // R3: annunciator flips when backplane 3 hands over to backplane 1
  a_r3_ann_flip: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started) && $past(activeMask) == 3'b100 && activeMask == 3'b001)
      |-> (annLvl != $past(annLvl)));

  // R4: every segment line is either bias or on the lit rail
  for (genvar i = 0; i < 12; i++) begin : g_line
    a_r4_seg_legal: assert property (@(posedge clk) disable iff (!rstN)
      started |-> (segLvl[2*i +: 2] == LVL_BIAS || segLvl[2*i +: 2] == annLvl));
  end
endmodule

bind lcd_triplex_drv lcd_triplex_chk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .bpLvl (bpLvl),
  .segLvl(segLvl),
  .annLvl(annLvl)
);

// File: tb/lcd_triplex_drv_tb_top.sv
`timescale 1ns/1ps
module lcd_triplex_drv_tb_top;
  localparam int SC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] digits = '0;
  logic [3:0]  dpEn = '0;
  logic        signOn = 0, halfOn = 0, lowBat = 0, contOn = 0;
  logic [5:0]  bpLvl;
  logic [23:0] segLvl;
  logic [1:0]  annLvl;

  int checkCnt = 0;
  int failCnt  = 0;
  int edgeCnt  = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  lcd_triplex_drv #(.SLOT_CYCLES(SC)) dut_i (
    .clk(clk), .rstN(rstN), .digits(digits), .dpEn(dpEn),
    .signOn(signOn), .halfOn(halfOn), .lowBat(lowBat), .contOn(contOn),
    .bpLvl(bpLvl), .segLvl(segLvl), .annLvl(annLvl)
  );

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  // R7 segment sets, bit 0 = A .. bit 6 = G
  function automatic logic [6:0] refSegs(input int v);
    case (v)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      9: return 7'b1101111;
      default: return 7'b0000000; // R8
    endcase
  endfunction

  task automatic checkNow(input string tag);
    int slot, bp;
    bit neg, lead;
    logic [1:0] litRail, bpRail, expBp [3], expSeg [12], expAnn;
    logic [6:0] sg [4];
    bit blankD [4];
    bit trio [12][3];
    bit extra [4];
    string msg;
    bit bad;
    slot = ((edgeCnt - 1) / SC) % 6;
    bp   = slot % 3;
    neg  = (slot >= 3);
    litRail = neg ? 2'b10 : 2'b00;
    bpRail  = neg ? 2'b00 : 2'b10;
    // R9 leading-zero rule
    lead = !halfOn;
    for (int k = 3; k >= 0; k--) begin
      int c = int'(digits[4*k +: 4]);
      blankD[k] = (c >= 10) || (lead && c == 0 && k != 0);
      lead = lead && (c == 0 || c >= 10);
      sg[k] = blankD[k] ? 7'b0 : refSegs(c);
    end
    extra[0] = contOn; extra[1] = lowBat; extra[2] = signOn; extra[3] = halfOn; // R6
    for (int d = 0; d < 4; d++) begin // R5
      trio[3*d][0] = sg[d][1];   trio[3*d][1] = sg[d][2];   trio[3*d][2] = extra[d];
      trio[3*d+1][0] = sg[d][0]; trio[3*d+1][1] = sg[d][6]; trio[3*d+1][2] = sg[d][3];
      trio[3*d+2][0] = sg[d][5]; trio[3*d+2][1] = sg[d][4]; trio[3*d+2][2] = dpEn[d]; // R10
    end
    for (int b = 0; b < 3; b++) expBp[b] = (b == bp) ? bpRail : 2'b01;
    for (int i = 0; i < 12; i++) expSeg[i] = trio[i][bp] ? litRail : 2'b01;
    expAnn = litRail;
    bad = 0;
    msg = "";
    for (int b = 0; b < 3; b++)
      if (bpLvl[2*b +: 2] !== expBp[b]) begin
        bad = 1;
        msg = $sformatf("backplane %0d got %b exp %b", b+1, bpLvl[2*b +: 2], expBp[b]);
      end
    for (int i = 0; i < 12; i++)
      if (segLvl[2*i +: 2] !== expSeg[i]) begin
        bad = 1;
        msg = $sformatf("line %0d got %b exp %b", i, segLvl[2*i +: 2], expSeg[i]);
      end
    if (annLvl !== expAnn) begin
      bad = 1;
      msg = $sformatf("annunciator got %b exp %b", annLvl, expAnn);
    end
    checkCnt++;
    if (bad) begin
      failCnt++;
      if (failCnt < 20)
        $display("FAIL %s slot %0d digits %h dp %b: %s", tag, slot, digits, dpEn, msg);
    end
  endtask

  // apply a stimulus, then compare every cycle of one full frame
  // R2 R3 R4 R11 are judged by every call
  task automatic runVec(input logic [15:0] dg, input logic [3:0] dp,
                        input logic sg, input logic hf, input logic lb,
                        input logic ct, input string tag);
    @(negedge clk);
    digits = dg; dpEn = dp; signOn = sg; halfOn = hf; lowBat = lb; contOn = ct;
    repeat (6*SC) begin
      @(negedge clk);
      checkNow({tag, " R2 R3 R4 R11"});
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R1: bias during reset
    digits = 16'h8888; dpEn = 4'hF; signOn = 1; halfOn = 1; lowBat = 1; contOn = 1;
    repeat (3) begin
      @(negedge clk);
      checkCnt++;
      if (bpLvl !== 6'b010101 || annLvl !== 2'b01 || segLvl !== {12{2'b01}}) begin
        failCnt++;
        $display("FAIL R1 got bp %b seg %h ann %b exp all 01", bpLvl, segLvl, annLvl);
      end
    end
    rstN = 1'b1;
    @(negedge clk);
    checkNow("R1 R2 first slot");

    // R7 R8: every code in every position, suppression off
    for (int pos = 0; pos < 4; pos++)
      for (int v = 0; v < 16; v++) begin
        logic [15:0] dg = 16'h8888;
        dg[4*pos +: 4] = 4'(v);
        runVec(dg, 4'(v), v[0], 1'b1, v[1], v[2], "R5 R7 R8");
      end

    // R9: zero, five and blank code in every position, half digit on and off
    for (int hf = 0; hf < 2; hf++)
      for (int n = 0; n < 81; n++) begin
        logic [15:0] dg;
        int r = n;
        for (int k = 0; k < 4; k++) begin
          int t = r % 3;
          r = r / 3;
          dg[4*k +: 4] = (t == 0) ? 4'd0 : (t == 1) ? 4'd5 : 4'd15;
        end
        runVec(dg, 4'b0000, 1'b0, 1'(hf), 1'b0, 1'b0, "R8 R9");
      end

    // R6 R10: every flag and decimal point combination over blanked zeros
    for (int f = 0; f < 256; f++)
      runVec(16'h0000, 4'(f >> 4), f[3], f[2], f[1], f[0], "R6 R10 R9");

    done = 1;
    finishRun();
  end
endmodule